// File: doc/BRIEF.md
# Trace Exception and Post-Reset Interrupt Gate

This block sits beside the instruction sequencer of a processor core. At every instruction boundary it decides whether a single-step trace exception has to be taken. It also holds back all interrupt traffic, the non-maskable request included, from the moment of reset until the core has retired its first instruction. That first instruction is expected to set up the stack, so no exception frame can be pushed through an invalid pointer.

The block owns three flag fields: the trace-enable bit, the global interrupt-disable bit and the multi-level interrupt mask. The core loads these through a parallel load strobe, which covers both register-move instructions and the restore done by a return-from-exception. A trace request is raised only when the core runs in the prioritised-mask interrupt scheme and the trace-enable bit is set. The request stays up until the entry sequencer acknowledges it. On that acknowledge the block applies the entry values to its flags: tracing is turned off, interrupts are disabled, and the mask level is left as it was.

Top module: `exc_trace_gate`

## Requirements
- R1: While reset is held, and directly after it, `trace_req` is 0, `exr_t` is 0, `ccr_i` is 1 and `exr_imask` is all ones.
- R2: From reset until the first clock edge at which `insn_done` is 1, `irq_out` and `nmi_out` are 0 whatever `irq_in` and `nmi_in` are. After that edge they follow their inputs, subject to R8.
- R3: If `insn_done` is 1 at an edge while `exr_t` is 1, `icm` is 2'b10 and `insn_rte` is 0, then `trace_req` is 1 from that edge on.
- R4: When `icm` is any value other than 2'b10 (2'b00, 2'b01 or 2'b11), an instruction completion never raises `trace_req`, even with `exr_t` at 1.
- R5: The completion of a return-from-exception (`insn_done` together with `insn_rte` = 1) never raises `trace_req`.
- R6: Once raised, `trace_req` stays at 1 until an edge with `trace_ack` at 1, and it reads 0 after that edge.
- R7: At the acknowledge edge, `exr_t` becomes 0 and `ccr_i` becomes 1, while `exr_imask` keeps its value.
- R8: While `trace_req` is 1, `irq_out` and `nmi_out` are 0, so the trace exception is presented ahead of any interrupt at the same boundary.
- R9: After the acknowledge, pending requests reach `irq_out` and `nmi_out` again, so interrupts are taken inside the trace handler.
- R10: A `flag_load` edge writes `load_t`, `load_i` and `load_imask` into the fields. If it coincides with an acknowledge, the entry values win for `exr_t` and `ccr_i` and the loaded mask is kept. Loading `exr_t` = 0 stops further requests.
- R11: The interrupt-disable bit and the mask level have no effect on whether a trace request is raised.
- R12: A return that restores `exr_t` = 1 yields no request for the return itself. The next instruction completion does raise one.
- R13: `insn_done` must not be 1 while `trace_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_done | input | 1 | Instruction-complete strobe, one cycle per retired instruction |
| insn_rte | input | 1 | Qualifies `insn_done`: the retired instruction is a return-from-exception |
| icm | input | 2 | Interrupt control scheme; 2'b10 is the prioritised-mask scheme |
| flag_load | input | 1 | Loads the three flag fields |
| load_t | input | 1 | Trace-enable value to load |
| load_i | input | 1 | Interrupt-disable value to load |
| load_imask | input | 3 | Mask level to load |
| irq_in | input | 1 | Pending maskable interrupt from the arbiter |
| nmi_in | input | 1 | Pending non-maskable interrupt |
| trace_ack | input | 1 | Entry sequencer accepts the trace exception |
| trace_req | output | 1 | Trace exception request |
| irq_out | output | 1 | Maskable interrupt request after gating |
| nmi_out | output | 1 | Non-maskable request after gating |
| ccr_i | output | 1 | Interrupt-disable bit |
| exr_t | output | 1 | Trace-enable bit |
| exr_imask | output | 3 | Interrupt mask level |

## Verification
Two events can fall on the same boundary. The first is a trace request together with a pending interrupt. The bench holds `irq_in` and `nmi_in` high across a traced completion and expects both gated outputs to stay 0 while the request waits, then to come back the cycle after the acknowledge. The second is the acknowledge edge together with a flag load. The bench drives both in one cycle and expects the entry values for the trace and disable bits next to the loaded mask level.

// File: rtl/exc_gate_pkg.sv
// Shared widths and encodings for the trace/reset exception gate.
// Assumes a two-bit interrupt-control selector and a three-bit mask level.
package exc_gate_pkg;
    localparam int ICM_W     = 2;
    localparam int IMASK_W   = 3;

    typedef enum logic [ICM_W-1:0] {
        ICM_FLAT  = 2'b00,
        ICM_RSV1  = 2'b01,
        ICM_PRIO  = 2'b10,
        ICM_RSV3  = 2'b11
    } icm_e;

    typedef struct packed {
        logic               t;
        logic               i;
        logic [IMASK_W-1:0] imask;
    } flags_t;
endpackage

// File: rtl/exc_reset_lock.sv
// Post-reset interrupt lockout.
// Holds a lock flag from reset until the first retired instruction, so that
// no exception can be taken before software has set up its stack.
// Assumes insn_done is a single-cycle strobe.
module exc_reset_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic insn_done,
    output logic locked
);
    // Lock flag: set by reset, cleared by the first completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (insn_done)
            locked <= 1'b0;
    end

    assert_lock_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && insn_done) |=> !locked);
    assert_lock_stays_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> !locked);
endmodule

// File: rtl/exc_trace_req.sv
// Trace request generator.
// Raises a request at an instruction boundary when tracing is enabled in the
// selected interrupt-control scheme, skips return-from-exception completions,
// and holds the request until it is acknowledged.
// Assumes the core stalls retirement while the request is pending.
module exc_trace_req #(
    parameter int ICM_W     = exc_gate_pkg::ICM_W,
    parameter logic [ICM_W-1:0] TRACE_ICM = exc_gate_pkg::ICM_PRIO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             insn_rte,
    input  logic [ICM_W-1:0] icm,
    input  logic             t_bit,
    input  logic             ack,
    output logic             req
);
    logic raise;

    // Qualify a completion for tracing.
    always_comb raise = insn_done && !insn_rte && t_bit && (icm == TRACE_ICM);

    // Request register: acknowledge clears, a qualified completion sets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else if (req && ack)
            req <= 1'b0;
        else if (raise)
            req <= 1'b1;
    end

    assert_scheme_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(icm == TRACE_ICM && t_bit));
    assert_no_rte_trace_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(insn_done && !insn_rte));
    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);
    assert_no_done_while_pending_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !insn_done);
endmodule

// File: rtl/exc_flag_regs.sv
// Trace, interrupt-disable and mask-level flag storage.
// Loads a new set of flags on request. On exception entry it clears the
// trace bit and sets the disable bit, which overrides a load in the same
// cycle for those two bits. The mask level is never touched by entry.
module exc_flag_regs #(
    parameter int IMASK_W = exc_gate_pkg::IMASK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               load_t,
    input  logic               load_i,
    input  logic [IMASK_W-1:0] load_imask,
    input  logic               entry,
    output logic               t_bit,
    output logic               i_bit,
    output logic [IMASK_W-1:0] imask
);
    localparam logic [IMASK_W-1:0] IMASK_RST = '1;

    // Flag update: reset values, then load, then entry override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_bit <= 1'b0;
            i_bit <= 1'b1;
            imask <= IMASK_RST;
        end else begin
            if (load) begin
                t_bit <= load_t;
                i_bit <= load_i;
                imask <= load_imask;
            end
            if (entry) begin
                t_bit <= 1'b0;
                i_bit <= 1'b1;
            end
        end
    end

    assert_entry_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (!t_bit && i_bit));
    assert_entry_keeps_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && !load) |=> $stable(imask));
endmodule

// File: rtl/exc_trace_gate.sv
// Trace exception and post-reset interrupt gate (top level).
// Combines the reset lockout, the trace request generator and the flag
// storage. Interrupts are passed on only after the first retired
// instruction and never while a trace request is pending.
module exc_trace_gate #(
    parameter int ICM_W   = exc_gate_pkg::ICM_W,
    parameter int IMASK_W = exc_gate_pkg::IMASK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_done,
    input  logic               insn_rte,
    input  logic [ICM_W-1:0]   icm,
    input  logic               flag_load,
    input  logic               load_t,
    input  logic               load_i,
    input  logic [IMASK_W-1:0] load_imask,
    input  logic               irq_in,
    input  logic               nmi_in,
    input  logic               trace_ack,
    output logic               trace_req,
    output logic               irq_out,
    output logic               nmi_out,
    output logic               ccr_i,
    output logic               exr_t,
    output logic [IMASK_W-1:0] exr_imask
);
    logic locked;
    logic entry;
    logic irq_open;

    exc_reset_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .locked    (locked)
    );

    exc_trace_req #(
        .ICM_W     (ICM_W),
        .TRACE_ICM (exc_gate_pkg::ICM_PRIO)
    ) u_trace (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .insn_rte  (insn_rte),
        .icm       (icm),
        .t_bit     (exr_t),
        .ack       (trace_ack),
        .req       (trace_req)
    );

    // Exception entry happens on an accepted trace request.
    always_comb entry = trace_req && trace_ack;

    exc_flag_regs #(
        .IMASK_W (IMASK_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (flag_load),
        .load_t     (load_t),
        .load_i     (load_i),
        .load_imask (load_imask),
        .entry      (entry),
        .t_bit      (exr_t),
        .i_bit      (ccr_i),
        .imask      (exr_imask)
    );

    // Interrupt gating: open after lockout, closed while trace waits.
    always_comb begin
        irq_open = !locked && !trace_req;
        irq_out  = irq_in && irq_open;
        nmi_out  = nmi_in && irq_open;
    end

    assert_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!irq_out && !nmi_out));
    assert_trace_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trace_req |-> (!irq_out && !nmi_out));
    assert_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && !insn_rte && exr_t && icm == exc_gate_pkg::ICM_PRIO) |=> trace_req);
endmodule

// File: tb/exc_trace_gate_tb.sv
// Self-checking bench: vector table walk, then directed corner cases.
module exc_trace_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done = 1'b0, insn_rte = 1'b0;
    logic [1:0] icm = 2'b10;
    logic       flag_load = 1'b0, load_t = 1'b0, load_i = 1'b0;
    logic [2:0] load_imask = 3'b000;
    logic       irq_in = 1'b0, nmi_in = 1'b0, trace_ack = 1'b0;
    logic       trace_req, irq_out, nmi_out, ccr_i, exr_t;
    logic [2:0] exr_imask;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    exc_trace_gate dut_i (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .insn_rte(insn_rte),
        .icm(icm), .flag_load(flag_load), .load_t(load_t), .load_i(load_i),
        .load_imask(load_imask), .irq_in(irq_in), .nmi_in(nmi_in),
        .trace_ack(trace_ack), .trace_req(trace_req), .irq_out(irq_out),
        .nmi_out(nmi_out), .ccr_i(ccr_i), .exr_t(exr_t), .exr_imask(exr_imask)
    );

    // Vector: {icm[1:0], t, rte, i, imask[2:0], expected_trace}
    localparam int NV = 9;
    localparam logic [8:0] VEC [NV] = '{
        {2'b10, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b1, 3'b111, 1'b1},
        {2'b10, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0},
        {2'b00, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0},
        {2'b01, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b0, 3'b010, 1'b0},
        {2'b10, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0},
        {2'b00, 1'b0, 1'b0, 1'b1, 3'b101, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b1, 3'b011, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load_flags(input logic t, input logic i, input logic [2:0] m);
        @(negedge clk);
        flag_load = 1'b1; load_t = t; load_i = i; load_imask = m;
        @(negedge clk);
        flag_load = 1'b0;
    endtask

    task automatic retire(input logic rte);
        @(negedge clk);
        insn_done = 1'b1; insn_rte = rte;
        @(negedge clk);
        insn_done = 1'b0; insn_rte = 1'b0;
    endtask

    task automatic ack_once();
        @(negedge clk);
        trace_ack = 1'b1;
        @(negedge clk);
        trace_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        irq_in = 1'b1; nmi_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 trace_req in reset", {7'b0, trace_req}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 exr_t", {7'b0, exr_t}, 8'd0);
        chk("R1 ccr_i", {7'b0, ccr_i}, 8'd1);
        chk("R1 exr_imask", {5'b0, exr_imask}, 8'd7);
        chk("R2 irq locked", {7'b0, irq_out}, 8'd0);
        chk("R2 nmi locked", {7'b0, nmi_out}, 8'd0);
        repeat (3) @(negedge clk);
        chk("R2 nmi still locked", {7'b0, nmi_out}, 8'd0);
        retire(1'b0);
        chk("R2 irq released", {7'b0, irq_out}, 8'd1);
        chk("R2 nmi released", {7'b0, nmi_out}, 8'd1);

        // Table walk: R3, R4, R5, R11 with R7, R8, R9 on each raised request.
        for (int k = 0; k < NV; k++) begin
            icm = VEC[k][8:7];
            load_flags(VEC[k][6], VEC[k][4], VEC[k][3:1]);
            retire(VEC[k][5]);
            chk($sformatf("R3/R4/R5/R11 vec %0d trace_req", k), {7'b0, trace_req}, {7'b0, VEC[k][0]});
            if (VEC[k][0]) begin
                chk($sformatf("R8 vec %0d irq held", k), {6'b0, irq_out, nmi_out}, 8'd0);
                ack_once();
                chk($sformatf("R6 vec %0d cleared", k), {7'b0, trace_req}, 8'd0);
                chk($sformatf("R7 vec %0d flags", k), {3'b0, exr_t, ccr_i, exr_imask},
                    {3'b0, 1'b0, 1'b1, VEC[k][3:1]});
                chk($sformatf("R9 vec %0d irq open", k), {6'b0, irq_out, nmi_out}, 8'd3);
            end
        end

        // R6: held without acknowledge.
        icm = 2'b10;
        load_flags(1'b1, 1'b0, 3'b001);
        retire(1'b0);
        repeat (4) @(negedge clk);
        chk("R6 held without ack", {7'b0, trace_req}, 8'd1);
        chk("R8 irq blocked while held", {6'b0, irq_out, nmi_out}, 8'd0);

        // R10: acknowledge coincides with a load.
        @(negedge clk);
        trace_ack = 1'b1; flag_load = 1'b1; load_t = 1'b1; load_i = 1'b0; load_imask = 3'b010;
        @(negedge clk);
        trace_ack = 1'b0; flag_load = 1'b0;
        chk("R10 ack wins t/i, mask loaded", {3'b0, exr_t, ccr_i, exr_imask}, {3'b0, 1'b0, 1'b1, 3'b010});
        chk("R10 request cleared", {7'b0, trace_req}, 8'd0);

        // R12: restored trace bit with a return, then the next instruction.
        load_flags(1'b1, 1'b0, 3'b010);
        retire(1'b1);
        chk("R12 no trace on return", {7'b0, trace_req}, 8'd0);
        retire(1'b0);
        chk("R12 trace after return", {7'b0, trace_req}, 8'd1);
        ack_once();

        // R10: clearing the trace bit stops requests.
        load_flags(1'b0, 1'b0, 3'b000);
        retire(1'b0);
        chk("R10 cleared t stops trace", {7'b0, trace_req}, 8'd0);

        // R1/R2: reset mid-run returns to lockout.
        load_flags(1'b1, 1'b0, 3'b000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 flags after re-reset", {3'b0, exr_t, ccr_i, exr_imask}, {3'b0, 1'b0, 1'b1, 3'b111});
        chk("R2 lock after re-reset", {6'b0, irq_out, nmi_out}, 8'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule